// File: doc/BRIEF.md
# Moore Controller with State-to-Set Code Transformer

This block is a seven-state Moore control unit. Its state lives in a 3-bit register of D flip-flops whose inputs are driven directly by the next-state code. Four condition inputs steer the transitions. The outputs are a set of four microoperation lines, and they are not decoded straight from the state. The registered state first passes through a code transformer, which reduces it to a 2-bit code naming one of four distinct output sets. A small table then expands that set code into the four microoperation lines.

Because the machine is of Moore type, the outputs depend on the current state only. A new output pattern appears after the clock edge that updates the state register, and it holds for the whole cycle whatever the conditions do. The state code and the set code are also brought out on debug ports so that the two-level output path can be observed.

Top module: `moore_xform_ctl`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state becomes 000, the set code 00 and `ops_o` 0000 after that edge, whatever `cond_i` holds. Reset takes priority over every transition.
- R2: From state 000 the next state is 001 when cond_i[0]=1, whatever cond_i[1] holds. When cond_i[0]=0 the next state is 010 if cond_i[1]=1 and 011 if cond_i[1]=0.
- R3: From states 001, 010 and 011 the next state is 100 when cond_i[2]=1 and 101 when cond_i[2]=0.
- R4: From states 100 and 101 the next state is 110 when cond_i[3]=1 and 000 when cond_i[3]=0.
- R5: From state 110 the next state is 100 when cond_i[2]=1 and 101 when cond_i[2]=0.
- R6: The set code on `set_dbg_o` is 00 for state 000, 01 for 001, 011 and 101, 10 for 010, and 11 for 100 and 110.
- R7: `ops_o` (bit 0 = first microoperation) is 0000 for set code 00, 0011 for 01, 0100 for 10 and 1100 for 11.
- R8: Changes on `cond_i` between clock edges have no effect on `set_dbg_o` or `ops_o`. The outputs change only after a clock edge that changes the state.
- R9: The state code never takes the unused value 111. If it were ever held, the next clock would return it to 000, with set code 00 in the meantime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 4 | Logic conditions; bit 0 is the first condition |
| ops_o | output | 4 | Microoperation outputs; bit 0 is the first microoperation |
| state_dbg_o | output | 3 | Current registered state code |
| set_dbg_o | output | 2 | Set-of-microoperations code from the transformer |

## Verification
Two functions can fall in the same cycle: the synchronous reset and a transition, when conditions that would move the machine are present at the edge where reset is sampled. The bench provokes this in two ways. It holds all conditions high during reset, and it also asserts reset while the machine sits in a state that would otherwise advance. The outcome is correct only if the state, set code and outputs all read zero after that edge. Separately, the conditions are toggled in the middle of a cycle to show that the Moore outputs stay fixed until the next edge.

// File: rtl/moore_xform_pkg.sv
package moore_xform_pkg;
  localparam int STATE_W = 3;
  localparam int SET_W   = 2;
  localparam int COND_W  = 4;
  localparam int OPS_W   = 4;

  typedef logic [STATE_W-1:0] state_t;
  typedef logic [SET_W-1:0]   set_t;
  typedef logic [COND_W-1:0]  cond_t;
  typedef logic [OPS_W-1:0]   ops_t;

  // state codes (the transition and conversion rules depend on these values)
  localparam state_t ST_HOME  = 3'b000;
  localparam state_t ST_TAKE  = 3'b001;
  localparam state_t ST_ALT   = 3'b010;
  localparam state_t ST_FALL  = 3'b011;
  localparam state_t ST_MERGE = 3'b100;
  localparam state_t ST_SPLIT = 3'b101;
  localparam state_t ST_TAIL  = 3'b110;

  localparam set_t SET_NONE  = 2'b00;
  localparam set_t SET_PAIR  = 2'b01;
  localparam set_t SET_THIRD = 2'b10;
  localparam set_t SET_UPPER = 2'b11;

  // next-state code; it also drives the D inputs of the state register
  function automatic state_t next_code(state_t s, cond_t c);
    state_t n;
    case (s)
      ST_HOME:                 n = c[0] ? ST_TAKE : (c[1] ? ST_ALT : ST_FALL);
      ST_TAKE, ST_ALT, ST_FALL: n = c[2] ? ST_MERGE : ST_SPLIT;
      ST_MERGE, ST_SPLIT:      n = c[3] ? ST_TAIL : ST_HOME;
      ST_TAIL:                 n = c[2] ? ST_MERGE : ST_SPLIT;
      default:                 n = ST_HOME;
    endcase
    return n;
  endfunction

  // code transformer: state code to set-of-microoperations code
  function automatic set_t set_of(state_t s);
    set_t k;
    case (s)
      ST_TAKE, ST_FALL, ST_SPLIT: k = SET_PAIR;
      ST_ALT:                     k = SET_THIRD;
      ST_MERGE, ST_TAIL:          k = SET_UPPER;
      default:                    k = SET_NONE;
    endcase
    return k;
  endfunction

  // one output line of the microoperation table
  function automatic logic op_bit(set_t k, int idx);
    logic b;
    case (idx)
      0, 1:    b = (k == SET_PAIR);
      2:       b = k[1];
      3:       b = (k == SET_UPPER);
      default: b = 1'b0;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/mx_next_logic.sv
module mx_next_logic
  import moore_xform_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_t state_i,
  input  cond_t  cond_i,
  output state_t excite_o
);
  assign excite_o = next_code(state_i, cond_i);

  // R2
  home_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (state_i == ST_HOME && !cond_i[0]) |-> (excite_o == ST_ALT || excite_o == ST_FALL));

  // R4
  exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_i == ST_MERGE || state_i == ST_SPLIT) |-> (excite_o == ST_TAIL || excite_o == ST_HOME));
endmodule

// File: rtl/mx_code_xform.sv
module mx_code_xform
  import moore_xform_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_t state_i,
  output set_t   set_o
);
  assign set_o = set_of(state_i);

  // R6
  empty_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_o == SET_NONE) |-> (state_i == ST_HOME || state_i == 3'b111));
endmodule

// File: rtl/mx_op_table.sv
module mx_op_table
  import moore_xform_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  set_t set_i,
  output ops_t ops_o
);
  for (genvar gi = 0; gi < OPS_W; gi++) begin : g_line
    assign ops_o[gi] = op_bit(set_i, gi);
  end

  // R7
  pair_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (ops_o[0] == ops_o[1]) && $onehot0({ops_o[0], ops_o[2]}) && (!ops_o[3] || ops_o[2]));
endmodule

// File: rtl/moore_xform_ctl.sv
module moore_xform_ctl
  import moore_xform_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] cond_i,
  output logic [OPS_W-1:0]  ops_o,
  output logic [STATE_W-1:0] state_dbg_o,
  output logic [SET_W-1:0]  set_dbg_o
);
  state_t state_q;
  state_t excite;
  set_t   set_code;

  mx_next_logic u_next (
    .clk(clk), .rst(rst), .state_i(state_q), .cond_i(cond_i), .excite_o(excite)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_HOME;
    else     state_q <= excite;
  end

  mx_code_xform u_xform (
    .clk(clk), .rst(rst), .state_i(state_q), .set_o(set_code)
  );

  mx_op_table u_table (
    .clk(clk), .rst(rst), .set_i(set_code), .ops_o(ops_o)
  );

  assign state_dbg_o = state_q;
  assign set_dbg_o   = set_code;

  // R1
  reset_home_chk: assert property (@(posedge clk) rst |=> (state_q == ST_HOME && ops_o == '0));

  // R8
  moore_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(state_q) |-> ($stable(set_code) && $stable(ops_o)));

  // R9
  illegal_recover_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == 3'b111) |=> (state_q == ST_HOME));

  // R3
  join_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_TAKE || state_q == ST_ALT || state_q == ST_FALL) && cond_i[2]) |=> (state_q == ST_MERGE));
endmodule

// File: tb/test_moore_xform_ctl.sv
module test_moore_xform_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cond_i = 4'b0000;
  logic [3:0] ops_o;
  logic [2:0] state_dbg_o;
  logic [1:0] set_dbg_o;

  int checks = 0;
  int errors = 0;

  moore_xform_ctl i_moore_xform_ctl (
    .clk(clk), .rst(rst), .cond_i(cond_i),
    .ops_o(ops_o), .state_dbg_o(state_dbg_o), .set_dbg_o(set_dbg_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [3:0] mk(bit a, bit b, bit c, bit d);
    return {d, c, b, a};
  endfunction

  function automatic logic [1:0] exp_set(logic [2:0] s);
    if (s == 3'd1 || s == 3'd3 || s == 3'd5) return 2'b01;
    if (s == 3'd2) return 2'b10;
    if (s == 3'd4 || s == 3'd6) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [3:0] exp_ops(logic [1:0] k);
    logic [3:0] r;
    r = 4'b0000;
    if (k == 2'b01) r = 4'b0011;
    if (k == 2'b10) r = 4'b0100;
    if (k == 2'b11) r = 4'b1100;
    return r;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_state(string req, logic [2:0] s);
    chk(req, {5'b0, state_dbg_o}, {5'b0, s});
    chk("R6", {6'b0, set_dbg_o}, {6'b0, exp_set(s)});
    chk("R7", {4'b0, ops_o}, {4'b0, exp_ops(exp_set(s))});
    chk("R9", {7'b0, state_dbg_o == 3'b111}, 8'd0);
  endtask

  // drive conditions, take one edge, sample 5 ns after it
  task automatic step(logic [3:0] c);
    cond_i = c;
    @(posedge clk);
    #5;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(4'b1111);
    step(4'b1111);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_state("R1", 3'd0);
    step(mk(1, 0, 0, 0));
    step(mk(0, 0, 1, 0));            // now 100
    rst = 1'b1;
    step(4'b1111);                   // reset wins over a transition to 110
    chk_state("R1", 3'd0);
    rst = 1'b0;
  endtask

  task automatic t_home();
    do_reset(); step(mk(1, 1, 0, 0)); chk_state("R2", 3'd1);
    do_reset(); step(mk(1, 0, 0, 0)); chk_state("R2", 3'd1);
    do_reset(); step(mk(0, 1, 0, 0)); chk_state("R2", 3'd2);
    do_reset(); step(mk(0, 0, 1, 1)); chk_state("R2", 3'd3);
  endtask

  task automatic t_join();
    logic [3:0] pre [3];
    pre[0] = mk(1, 0, 0, 0); pre[1] = mk(0, 1, 0, 0); pre[2] = mk(0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      do_reset(); step(pre[i]); step(mk(0, 0, 1, 0)); chk_state("R3", 3'd4);
      do_reset(); step(pre[i]); step(mk(1, 1, 0, 1)); chk_state("R3", 3'd5);
    end
  endtask

  task automatic t_exit();
    do_reset(); step(mk(1, 0, 0, 0)); step(mk(0, 0, 1, 0));
    step(mk(0, 0, 0, 1)); chk_state("R4", 3'd6);
    do_reset(); step(mk(1, 0, 0, 0)); step(mk(0, 0, 1, 0));
    step(mk(1, 1, 1, 0)); chk_state("R4", 3'd0);
    do_reset(); step(mk(1, 0, 0, 0)); step(mk(0, 0, 0, 0));
    step(mk(0, 0, 0, 1)); chk_state("R4", 3'd6);
    do_reset(); step(mk(1, 0, 0, 0)); step(mk(0, 0, 0, 0));
    step(mk(0, 0, 0, 0)); chk_state("R4", 3'd0);
  endtask

  task automatic t_tail();
    do_reset(); step(mk(1, 0, 0, 0)); step(mk(0, 0, 1, 0)); step(mk(0, 0, 0, 1));
    step(mk(0, 0, 1, 0)); chk_state("R5", 3'd4);
    step(mk(0, 0, 0, 1)); chk_state("R5", 3'd6);
    step(mk(1, 1, 0, 1)); chk_state("R5", 3'd5);
  endtask

  task automatic t_moore();
    do_reset(); step(mk(0, 1, 0, 0));  // 010, set 10
    @(negedge clk);
    cond_i = 4'b1111; #3;
    chk("R8", {4'b0, ops_o}, 8'b0000_0100);
    cond_i = 4'b0000; #3;
    chk("R8", {6'b0, set_dbg_o}, 8'd2);
    cond_i = 4'b0100; #3;
    chk("R8", {4'b0, ops_o}, 8'b0000_0100);
    @(posedge clk); #5;
    chk_state("R8", 3'd4);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_home();
        t_join();
        t_exit();
        t_tail();
        t_moore();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule